// File: doc/BRIEF.md
# Machine Timer Unit

This block holds a 64-bit machine time counter and a 64-bit compare value for a single hart, and presents them through a small 32-bit register window. While the counter is at or above the compare value the block holds its timer interrupt high; a separate software interrupt line follows bit 0 of a register that software writes. Software can freeze the counter, overwrite either half of it, and return the whole block to its power-on state with one command write.

The counter advances by one on each cycle where `tick_en` is high, so the time base is set by whatever drives that input. The bus port is a plain single-cycle register port. A write is taken on the clock edge where `bus_sel` and `bus_we` are high. Read data is a combinational function of the address and the current register values, and it is returned in the same cycle. Only aligned 32-bit accesses are supported. An address that is not listed reads as zero, and a write to it is dropped.

Top module: `mtimer_unit`

## Requirements
- R1: After reset the counter reads 0 and both compare words read 0xFFFFFFFF. The stop register and the software-interrupt register read 0. Both interrupt outputs are low.
- R2: While stop bit 0 is clear, each cycle with `tick_en` high adds one to the 64-bit counter. A carry out of the low word (offset 0x000) goes into the high word (offset 0x004).
- R3: While bit 0 of the stop register (offset 0xFF8) is set, the counter holds its value through tick pulses. The stop register reads back the full 32-bit value written to it.
- R4: A write to offset 0x000 or 0x004 replaces only that half of the counter. Such a write overrides a tick in the same cycle, so no increment is applied in that cycle.
- R5: A write to the low compare word (offset 0x008) loads that word and sets the high compare word (offset 0x00C) to 0xFFFFFFFF in the same cycle. A write to 0x00C replaces only the high compare word.
- R6: `irq_timer` is registered. In each cycle it shows whether the counter was greater than or equal to the compare value (unsigned, 64-bit) in the previous cycle.
- R7: Bit 0 of the software-interrupt register (offset 0xFFC) drives `irq_soft` from the cycle after the write. The register reads back the full 32-bit value written.
- R8: A write to offset 0xFF0 with bit 31 set puts every register and both interrupt outputs back in their reset state on the next cycle. A write there with bit 31 clear changes nothing. Offset 0xFF0 reads as zero.
- R9: Any offset other than 0x000, 0x004, 0x008, 0x00C, 0xFF0, 0xFF8 and 0xFFC reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Advances the counter by one in this cycle |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| irq_timer | output | 1 | Level timer interrupt |
| irq_soft | output | 1 | Level software interrupt |

## Verification
The assertions assume a bus that issues at most one access per cycle and keeps every input at a defined level while the internal reset is released. They also assume that a write to the counter, compare, or command offsets is the only thing that can change those registers in that cycle. The bench drives all inputs half a cycle away from the active edge and issues exactly one access, or none, in each step. It combines tick pulses with writes to the same and to other offsets, so that the override and freeze rules are exercised without any overlapping transactions.

// File: rtl/mtu_pkg.sv
package mtu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned TIME_W = 2 * WORD_W;

  localparam int unsigned OFF_CNT_LO = 'h000;
  localparam int unsigned OFF_CNT_HI = 'h004;
  localparam int unsigned OFF_CMP_LO = 'h008;
  localparam int unsigned OFF_CMP_HI = 'h00C;
  localparam int unsigned OFF_SRST   = 'hFF0;
  localparam int unsigned OFF_STOP   = 'hFF8;
  localparam int unsigned OFF_SWI    = 'hFFC;

  localparam int unsigned SRST_KEY_BIT = 31;

  typedef struct packed {
    logic cnt_lo;
    logic cnt_hi;
    logic cmp_lo;
    logic cmp_hi;
    logic srst;
    logic stop;
    logic swi;
  } mtu_hit_t;
endpackage

// File: rtl/mtu_decode.sv
module mtu_decode #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output mtu_pkg::mtu_hit_t hit
);
  import mtu_pkg::*;

  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFF_CNT_LO);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFF_CNT_HI);
  localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(OFF_CMP_LO);
  localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(OFF_CMP_HI);
  localparam logic [ADDR_W-1:0] A_SRST   = ADDR_W'(OFF_SRST);
  localparam logic [ADDR_W-1:0] A_STOP   = ADDR_W'(OFF_STOP);
  localparam logic [ADDR_W-1:0] A_SWI    = ADDR_W'(OFF_SWI);

  always_comb begin
    hit        = '0;
    hit.cnt_lo = sel && (addr == A_CNT_LO);
    hit.cnt_hi = sel && (addr == A_CNT_HI);
    hit.cmp_lo = sel && (addr == A_CMP_LO);
    hit.cmp_hi = sel && (addr == A_CMP_HI);
    hit.srst   = sel && (addr == A_SRST);
    hit.stop   = sel && (addr == A_STOP);
    hit.swi    = sel && (addr == A_SWI);
  end
endmodule

// File: rtl/mtu_counter.sv
module mtu_counter #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned TIME_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              tick,
  input  logic              run,
  input  logic [WORD_W-1:0] wdata,
  output logic [TIME_W-1:0] cnt_q
);
  logic [TIME_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = clr || wr_lo || wr_hi || (tick && run);
    if (clr) begin
      cnt_d = '0;
    end else if (wr_lo) begin
      cnt_d[WORD_W-1:0] = wdata;
    end else if (wr_hi) begin
      cnt_d[TIME_W-1:WORD_W] = wdata;
    end else if (tick && run) begin
      cnt_d = cnt_q + TIME_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/mtu_compare.sv
module mtu_compare #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned TIME_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic [TIME_W-1:0] cnt_q,
  output logic [TIME_W-1:0] cmp_q,
  output logic              irq_q
);
  logic [TIME_W-1:0] cmp_d;
  logic              cmp_en;
  logic              irq_d;

  always_comb begin
    cmp_d  = cmp_q;
    cmp_en = clr || wr_lo || wr_hi;
    if (clr) begin
      cmp_d = '1;
    end else if (wr_lo) begin
      cmp_d = {{WORD_W{1'b1}}, wdata};
    end else if (wr_hi) begin
      cmp_d[TIME_W-1:WORD_W] = wdata;
    end
    irq_d = !clr && (cnt_q >= cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
      irq_q <= 1'b0;
    end else begin
      if (cmp_en) begin
        cmp_q <= cmp_d;
      end
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_en,
  input  logic                       bus_sel,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [mtu_pkg::WORD_W-1:0] bus_wdata,
  output logic [mtu_pkg::WORD_W-1:0] bus_rdata,
  output logic                       irq_timer,
  output logic                       irq_soft
);
  import mtu_pkg::*;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  mtu_hit_t          hit;
  logic              wr;
  logic              srst;
  logic [TIME_W-1:0] cnt_q;
  logic [TIME_W-1:0] cmp_q;
  logic [WORD_W-1:0] stop_q, stop_d;
  logic [WORD_W-1:0] swi_q, swi_d;
  logic              ctl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  mtu_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel  (bus_sel),
    .addr (bus_addr),
    .hit  (hit)
  );

  assign wr   = bus_we;
  assign srst = wr && hit.srst && bus_wdata[SRST_KEY_BIT];

  mtu_counter #(.WORD_W(WORD_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (srst),
    .wr_lo (wr && hit.cnt_lo),
    .wr_hi (wr && hit.cnt_hi),
    .tick  (tick_en),
    .run   (!stop_q[0]),
    .wdata (bus_wdata),
    .cnt_q (cnt_q)
  );

  mtu_compare #(.WORD_W(WORD_W)) u_cmp (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (srst),
    .wr_lo (wr && hit.cmp_lo),
    .wr_hi (wr && hit.cmp_hi),
    .wdata (bus_wdata),
    .cnt_q (cnt_q),
    .cmp_q (cmp_q),
    .irq_q (irq_timer)
  );

  always_comb begin
    stop_d = stop_q;
    swi_d  = swi_q;
    ctl_en = srst || (wr && (hit.stop || hit.swi));
    if (srst) begin
      stop_d = '0;
      swi_d  = '0;
    end else begin
      if (wr && hit.stop) stop_d = bus_wdata;
      if (wr && hit.swi)  swi_d  = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stop_q <= '0;
      swi_q  <= '0;
    end else if (ctl_en) begin
      stop_q <= stop_d;
      swi_q  <= swi_d;
    end
  end

  assign irq_soft = swi_q[0];

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      unique case (1'b1)
        hit.cnt_lo: bus_rdata = cnt_q[WORD_W-1:0];
        hit.cnt_hi: bus_rdata = cnt_q[TIME_W-1:WORD_W];
        hit.cmp_lo: bus_rdata = cmp_q[WORD_W-1:0];
        hit.cmp_hi: bus_rdata = cmp_q[TIME_W-1:WORD_W];
        hit.stop:   bus_rdata = stop_q;
        hit.swi:    bus_rdata = swi_q;
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mtu_checker.sv
module mtu_checker #(
  parameter int unsigned ADDR_W = 12
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          tick_en,
  input logic                          bus_sel,
  input logic                          bus_we,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [mtu_pkg::WORD_W-1:0]    bus_wdata,
  input logic [mtu_pkg::WORD_W-1:0]    bus_rdata,
  input logic                          irq_timer,
  input logic                          irq_soft,
  input logic [mtu_pkg::TIME_W-1:0]    cnt_q,
  input logic [mtu_pkg::TIME_W-1:0]    cmp_q,
  input logic                          stop_bit
);
  import mtu_pkg::*;

  logic wr, w_cnt, w_cmp_lo, w_swi, w_srst, mapped;
  assign wr       = bus_sel && bus_we;
  assign w_cnt    = wr && (bus_addr == ADDR_W'(OFF_CNT_LO) || bus_addr == ADDR_W'(OFF_CNT_HI));
  assign w_cmp_lo = wr && bus_addr == ADDR_W'(OFF_CMP_LO);
  assign w_swi    = wr && bus_addr == ADDR_W'(OFF_SWI);
  assign w_srst   = wr && bus_addr == ADDR_W'(OFF_SRST) && bus_wdata[SRST_KEY_BIT];
  assign mapped   = bus_addr == ADDR_W'(OFF_CNT_LO) || bus_addr == ADDR_W'(OFF_CNT_HI) ||
                    bus_addr == ADDR_W'(OFF_CMP_LO) || bus_addr == ADDR_W'(OFF_CMP_HI) ||
                    bus_addr == ADDR_W'(OFF_SRST)   || bus_addr == ADDR_W'(OFF_STOP)   ||
                    bus_addr == ADDR_W'(OFF_SWI);

  // R2
  p_tick_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !stop_bit && !w_cnt && !w_srst) |=> cnt_q == $past(cnt_q) + 64'd1);

  // R3
  p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_bit && !w_cnt && !w_srst) |=> $stable(cnt_q));

  // R5
  p_cmp_lo_forces_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    w_cmp_lo |=> cmp_q[TIME_W-1:WORD_W] == {WORD_W{1'b1}});

  // R6
  p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !w_srst |=> irq_timer == ($past(cnt_q) >= $past(cmp_q)));

  // R7
  p_soft_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    w_swi |=> irq_soft == $past(bus_wdata[0]));

  // R8
  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    w_srst |=> (cnt_q == '0 && cmp_q == '1 && !irq_timer && !irq_soft && !stop_bit));

  // R9
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !mapped) |-> bus_rdata == '0);
endmodule

bind mtimer_unit mtu_checker #(.ADDR_W(ADDR_W)) u_mtu_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tick_en   (tick_en),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_timer (irq_timer),
  .irq_soft  (irq_soft),
  .cnt_q     (cnt_q),
  .cmp_q     (cmp_q),
  .stop_bit  (stop_q[0])
);

// File: tb/tb_mtimer_unit.sv
module tb_mtimer_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_timer, irq_soft;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  longint unsigned m_cnt, m_cmp;
  int unsigned     m_stop, m_swi;
  bit              m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtimer_unit dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_timer(irq_timer), .irq_soft(irq_soft)
  );

  function automatic int unsigned model_read(input int unsigned a);
    case (a)
      'h000: return int'(m_cnt[31:0]);
      'h004: return int'(m_cnt[63:32]);
      'h008: return int'(m_cmp[31:0]);
      'h00C: return int'(m_cmp[63:32]);
      'hFF8: return m_stop;
      'hFFC: return m_swi;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_cmp = 64'hFFFF_FFFF_FFFF_FFFF; m_stop = 0; m_swi = 0; m_irq = 0;
  endtask

  task automatic step(input bit sel, input bit we, input int unsigned a,
                      input int unsigned wd, input bit tk, input string req);
    bit srst, run, cnt_wr, nirq;
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = a[11:0]; bus_wdata = wd; tick_en = tk;
    #1;
    if (sel && !we) check(req, bus_rdata, model_read(a));
    @(posedge clk);
    srst   = sel && we && a == 'hFF0 && wd[31];
    run    = (m_stop & 1) == 0;
    nirq   = !srst && (m_cnt >= m_cmp);
    cnt_wr = sel && we && (a == 'h000 || a == 'h004);
    if (srst) model_reset();
    else begin
      if (sel && we) begin
        case (a)
          'h000: m_cnt[31:0]  = wd;
          'h004: m_cnt[63:32] = wd;
          'h008: m_cmp = {32'hFFFF_FFFF, wd};
          'h00C: m_cmp[63:32] = wd;
          'hFF8: m_stop = wd;
          'hFFC: m_swi = wd;
          default: ;
        endcase
      end
      if (!cnt_wr && tk && run) m_cnt = m_cnt + 1;
    end
    m_irq = nirq;
    #1;
    check("R6 irq_timer", irq_timer, m_irq);
    check("R7 irq_soft", irq_soft, m_swi & 1);
  endtask

  task automatic wr(input int unsigned a, input int unsigned d, input bit tk = 0);
    step(1, 1, a, d, tk, "write");
  endtask

  task automatic rd(input int unsigned a, input string req);
    step(1, 0, a, 0, 0, req);
  endtask

  task automatic idle(input int n, input bit tk);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, tk, "idle");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd('h000, "R1 cnt lo"); rd('h004, "R1 cnt hi");
    rd('h008, "R1 cmp lo"); rd('h00C, "R1 cmp hi");
    rd('hFF8, "R1 stop");   rd('hFFC, "R1 swi");
    check("R1 irq_timer low", irq_timer, 0);

    // R2: counting and carry
    idle(5, 1);
    rd('h000, "R2 count after ticks");
    check("R2 count value", bus_rdata, 5);
    wr('h000, 32'hFFFF_FFFE); wr('h004, 32'h5);
    idle(2, 1);
    rd('h004, "R2 carry hi"); check("R2 carry hi value", bus_rdata, 6);
    rd('h000, "R2 carry lo"); check("R2 carry lo value", bus_rdata, 0);

    // R3: stop holds counter, full readback
    wr('hFF8, 32'hA5A5_0001);
    idle(4, 1);
    rd('h000, "R3 held lo"); check("R3 held value", bus_rdata, 0);
    rd('hFF8, "R3 stop readback"); check("R3 stop value", bus_rdata, 32'hA5A5_0001);
    wr('hFF8, 32'h0);
    idle(3, 1);
    rd('h000, "R3 resumed");

    // R4: write wins over tick, half replace
    wr('h000, 32'h1234_0000, 1);
    rd('h000, "R4 write over tick"); check("R4 value", bus_rdata, 32'h1234_0000);
    wr('h004, 32'h0000_00AB, 1);
    rd('h004, "R4 hi replaced"); rd('h000, "R4 lo kept");

    // R5 / R6: compare and timer interrupt
    wr('h000, 0); wr('h004, 0);
    wr('h00C, 0);
    wr('h008, 32'h10);
    rd('h00C, "R5 hi forced"); check("R5 hi value", bus_rdata, 32'hFFFF_FFFF);
    check("R6 no match while hi ones", irq_timer, 0);
    wr('h00C, 0);
    idle(20, 1);
    check("R6 irq raised", irq_timer, 1);
    wr('h00C, 1);
    idle(2, 0);
    check("R6 irq dropped", irq_timer, 0);

    // R7: software interrupt
    wr('hFFC, 32'hDEAD_0001);
    check("R7 irq_soft set", irq_soft, 1);
    rd('hFFC, "R7 readback");
    wr('hFFC, 32'h2);
    check("R7 irq_soft clear", irq_soft, 0);

    // R9: unmapped offsets
    wr('h010, 32'h123);
    rd('h010, "R9 unmapped read");
    rd('h002, "R9 misaligned read");
    rd('hFF4, "R9 gap read");
    rd('h000, "R9 counter untouched");

    // R8: soft reset command
    wr('hFFC, 1); wr('hFF8, 1);
    wr('hFF0, 32'h7FFF_FFFF);
    rd('hFF8, "R8 no effect stop"); rd('hFFC, "R8 no effect swi");
    rd('hFF0, "R8 reads zero"); check("R8 zero value", bus_rdata, 0);
    wr('hFF0, 32'h8000_0000, 1);
    rd('h000, "R8 cnt cleared"); rd('h00C, "R8 cmp set");
    rd('hFF8, "R8 stop cleared"); rd('hFFC, "R8 swi cleared");
    check("R8 irq_soft low", irq_soft, 0);
    idle(3, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule